// File: doc/BRIEF.md
# Windowed Register File

This block is a 32-entry architectural register file for a processor that switches register context on procedure call and return. Eight registers are globals shared by every context. The other 24 are taken from a larger physical bank through a current-window pointer. A save command moves the pointer forward by one window and a restore command moves it back by one. Adjacent windows share eight registers, so a caller's outgoing arguments appear as the callee's incoming ones without any copying.

The file has two combinational read ports and one write port, all addressed by architectural register number. It keeps a count of resident windows. A save that would need a window still holding live data raises an overflow pulse and leaves the pointer where it was. A restore with no resident window behind it raises an underflow pulse and also leaves the pointer unchanged. These pulses tell an external handler to spill a window to a memory stack or fill one from it. The handler itself is not part of this block.

Top module: `regwin_file`

## Requirements
- R1: Architectural registers 0 to 7 are globals. Each one refers to the same storage whichever window is current.
- R2: Register 0 always reads as zero on both read ports, including in the cycle it is written. A write to it is discarded.
- R3: A save with fewer than NWIN-1 windows resident increments the window pointer `cwp_o` at the clock edge. Reads in the next cycle use the new window.
- R4: A restore with more than one window resident decrements `cwp_o` at the clock edge. Reads in the next cycle use the new window.
- R5: Registers 8 to 15 (outs) of window w are the same storage as registers 24 to 31 (ins) of window w+1, with the window index taken modulo NWIN.
- R6: Registers 16 to 23 (locals) are private to their window. A write to a local in one window is not seen in any other window.
- R7: A save issued while NWIN-1 windows (7 by default) are resident raises `ovf_o` for exactly the one cycle after that edge, and `cwp_o` is unchanged.
- R8: A restore issued while only one window is resident raises `unf_o` for exactly the one cycle after that edge, and `cwp_o` is unchanged.
- R9: When a read port addresses the same physical register that is being written in that cycle, it returns the write data.
- R10: When save and restore are asserted together, neither takes effect. The pointer does not move and no flag is raised.
- R11: After reset the window pointer is 0, one window is resident, both flags are low and every register reads zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| save_i | input | 1 | Advance to the next window |
| restore_i | input | 1 | Return to the previous window |
| we_i | input | 1 | Write enable |
| waddr_i | input | 5 | Architectural write register |
| wdata_i | input | DW | Write data |
| raddr_a_i | input | 5 | Architectural register for read port A |
| rdata_a_o | output | DW | Read data A (combinational) |
| raddr_b_i | input | 5 | Architectural register for read port B |
| rdata_b_o | output | DW | Read data B (combinational) |
| cwp_o | output | $clog2(NWIN) | Current window pointer |
| ovf_o | output | 1 | One-cycle overflow pulse |
| unf_o | output | 1 | One-cycle underflow pulse |

## Verification
The read data is combinational, so the bench checks it in the same cycle the address is applied, with the inputs settled well away from the clock edge. This includes the same-cycle write bypass. A write shows up in ordinary reads in the cycle after its edge. The pointer and both flags change at the edge that samples the command, so the bench checks them just after that edge. It checks again one edge later to confirm that each flag lasts one cycle only. The bench sweeps every register of every reachable window using an arithmetic model of the physical mapping, so aliasing and privacy are checked against values computed independently of the design.

// File: rtl/regwin_pkg.sv
package regwin_pkg;
    localparam int unsigned AREG_W   = 5;
    localparam int unsigned GRP_SIZE = 8;
    localparam int unsigned NGLOB    = GRP_SIZE;
    localparam int unsigned IDX_W    = $clog2(GRP_SIZE);
    localparam int unsigned SLOT     = 2 * GRP_SIZE;

    typedef enum logic [1:0] {
        GRP_GLOBAL = 2'd0,
        GRP_OUT    = 2'd1,
        GRP_LOCAL  = 2'd2,
        GRP_IN     = 2'd3
    } grp_e;
endpackage

// File: rtl/regwin_map.sv
module regwin_map
    import regwin_pkg::*;
#(
    parameter int unsigned NWIN = 8,
    parameter int unsigned CW   = 3,
    parameter int unsigned PW   = 8
) (
    input  logic [CW-1:0]     cwp_i,
    input  logic [AREG_W-1:0] areg_i,
    output logic [PW-1:0]     phys_o
);
    logic [CW-1:0]    prev;
    grp_e             grp;
    logic [IDX_W-1:0] idx;

    always_comb begin
        prev = (cwp_i == '0) ? CW'(NWIN - 1) : cwp_i - 1'b1;
        grp  = grp_e'(areg_i[AREG_W-1 -: 2]);
        idx  = areg_i[IDX_W-1:0];
        unique case (grp)
            GRP_GLOBAL: phys_o = PW'(idx);
            GRP_OUT:    phys_o = PW'(NGLOB + int'(cwp_i) * SLOT + GRP_SIZE + int'(idx));
            GRP_LOCAL:  phys_o = PW'(NGLOB + int'(cwp_i) * SLOT + int'(idx));
            default:    phys_o = PW'(NGLOB + int'(prev) * SLOT + GRP_SIZE + int'(idx));
        endcase
    end
endmodule

// File: rtl/regwin_ctrl.sv
module regwin_ctrl #(
    parameter int unsigned NWIN = 8,
    parameter int unsigned CW   = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          save_i,
    input  logic          restore_i,
    output logic [CW-1:0] cwp_o,
    output logic          ovf_o,
    output logic          unf_o
);
    typedef struct packed {
        logic [CW-1:0] cwp;
        logic [CW-1:0] cnt;
        logic          ovf;
        logic          unf;
    } ctrl_t;

    ctrl_t q, d;

    always_comb begin
        d     = q;
        d.ovf = 1'b0;
        d.unf = 1'b0;
        if (save_i && !restore_i) begin
            if (q.cnt == CW'(NWIN - 1)) begin
                d.ovf = 1'b1;
            end else begin
                d.cwp = (q.cwp == CW'(NWIN - 1)) ? '0 : q.cwp + 1'b1;
                d.cnt = q.cnt + 1'b1;
            end
        end else if (restore_i && !save_i) begin
            if (q.cnt == CW'(1)) begin
                d.unf = 1'b1;
            end else begin
                d.cwp = (q.cwp == '0) ? CW'(NWIN - 1) : q.cwp - 1'b1;
                d.cnt = q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{cwp: '0, cnt: CW'(1), ovf: 1'b0, unf: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign cwp_o = q.cwp;
    assign ovf_o = q.ovf;
    assign unf_o = q.unf;

    p_save_moves_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (save_i && !restore_i && q.cnt != CW'(NWIN - 1)) |=>
        (q.cwp == (($past(q.cwp) == CW'(NWIN - 1)) ? '0 : $past(q.cwp) + 1'b1)));

    p_restore_moves_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (restore_i && !save_i && q.cnt != CW'(1)) |=>
        (q.cwp == (($past(q.cwp) == '0) ? CW'(NWIN - 1) : $past(q.cwp) - 1'b1)));

    p_overflow_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (save_i && !restore_i && q.cnt == CW'(NWIN - 1)) |=> (ovf_o && $stable(cwp_o)));

    p_underflow_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (restore_i && !save_i && q.cnt == CW'(1)) |=> (unf_o && $stable(cwp_o)));

    p_both_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (save_i && restore_i) |=> ($stable(cwp_o) && !ovf_o && !unf_o));

    p_flags_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ovf_o, unf_o}));

    p_cnt_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.cnt != '0) && (q.cnt <= CW'(NWIN - 1)));
endmodule

// File: rtl/regwin_bank.sv
module regwin_bank #(
    parameter int unsigned DW    = 32,
    parameter int unsigned NPHYS = 136,
    parameter int unsigned PW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_i,
    input  logic [PW-1:0] wphys_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [PW-1:0] rphys_a_i,
    output logic [DW-1:0] rdata_a_o,
    input  logic [PW-1:0] rphys_b_i,
    output logic [DW-1:0] rdata_b_o
);
    logic [DW-1:0] bank_q [NPHYS];
    logic [DW-1:0] bank_d [NPHYS];
    logic          wr_live;

    function automatic logic [DW-1:0] port_read(input logic [PW-1:0] rp,
                                                input logic           wl,
                                                input logic [PW-1:0]  wp,
                                                input logic [DW-1:0]  wd,
                                                input logic [DW-1:0]  stored);
        if (rp == '0)              return '0;
        else if (wl && (wp == rp)) return wd;
        else                       return stored;
    endfunction

    always_comb begin
        wr_live = we_i && (wphys_i != '0);
        bank_d  = bank_q;
        if (wr_live) begin
            bank_d[wphys_i] = wdata_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q <= '{default: '0};
        end else begin
            bank_q <= bank_d;
        end
    end

    assign rdata_a_o = port_read(rphys_a_i, wr_live, wphys_i, wdata_i, bank_q[rphys_a_i]);
    assign rdata_b_o = port_read(rphys_b_i, wr_live, wphys_i, wdata_i, bank_q[rphys_b_i]);

    p_write_lands_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_live && !we_i == 1'b0) ##1 (!we_i && rphys_a_i == $past(wphys_i))
        |-> (rdata_a_o == $past(wdata_i)));
endmodule

// File: rtl/regwin_file.sv
module regwin_file
    import regwin_pkg::*;
#(
    parameter int unsigned NWIN = 8,
    parameter int unsigned DW   = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    save_i,
    input  logic                    restore_i,
    input  logic                    we_i,
    input  logic [AREG_W-1:0]       waddr_i,
    input  logic [DW-1:0]           wdata_i,
    input  logic [AREG_W-1:0]       raddr_a_i,
    output logic [DW-1:0]           rdata_a_o,
    input  logic [AREG_W-1:0]       raddr_b_i,
    output logic [DW-1:0]           rdata_b_o,
    output logic [$clog2(NWIN)-1:0] cwp_o,
    output logic                    ovf_o,
    output logic                    unf_o
);
    localparam int unsigned CW    = $clog2(NWIN);
    localparam int unsigned NPHYS = NGLOB + NWIN * SLOT;
    localparam int unsigned PW    = $clog2(NPHYS);
    localparam int unsigned NPORT = 3;

    logic [CW-1:0]     cwp;
    logic [AREG_W-1:0] areg [NPORT];
    logic [PW-1:0]     phys [NPORT];

    assign areg[0] = waddr_i;
    assign areg[1] = raddr_a_i;
    assign areg[2] = raddr_b_i;

    regwin_ctrl #(.NWIN(NWIN), .CW(CW)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .save_i    (save_i),
        .restore_i (restore_i),
        .cwp_o     (cwp),
        .ovf_o     (ovf_o),
        .unf_o     (unf_o)
    );

    for (genvar p = 0; p < NPORT; p++) begin : g_map
        regwin_map #(.NWIN(NWIN), .CW(CW), .PW(PW)) u_map (
            .cwp_i  (cwp),
            .areg_i (areg[p]),
            .phys_o (phys[p])
        );
    end

    regwin_bank #(.DW(DW), .NPHYS(NPHYS), .PW(PW)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .we_i      (we_i),
        .wphys_i   (phys[0]),
        .wdata_i   (wdata_i),
        .rphys_a_i (phys[1]),
        .rdata_a_o (rdata_a_o),
        .rphys_b_i (phys[2]),
        .rdata_b_o (rdata_b_o)
    );

    assign cwp_o = cwp;

    p_zero_a_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (raddr_a_i == '0) |-> (rdata_a_o == '0));

    p_zero_b_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (raddr_b_i == '0) |-> (rdata_b_o == '0));

    p_bypass_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && waddr_i != '0 && waddr_i == raddr_a_i) |-> (rdata_a_o == wdata_i));

    p_global_fixed_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (raddr_b_i[AREG_W-1 -: 2] == GRP_GLOBAL) |-> (phys[2] == PW'(raddr_b_i)));
endmodule

// File: tb/sim_regwin_file.sv
module sim_regwin_file;
    localparam int NWIN  = 8;
    localparam int DW    = 32;
    localparam int NPHYS = 8 + NWIN * 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          save_i = 1'b0, restore_i = 1'b0, we_i = 1'b0;
    logic [4:0]    waddr_i = '0, raddr_a_i = '0, raddr_b_i = '0;
    logic [DW-1:0] wdata_i = '0;
    logic [DW-1:0] rdata_a_o, rdata_b_o;
    logic [2:0]    cwp_o;
    logic          ovf_o, unf_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    logic [DW-1:0] model [NPHYS];

    always #4 clk = ~clk;

    regwin_file #(.NWIN(NWIN), .DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .save_i(save_i), .restore_i(restore_i),
        .we_i(we_i), .waddr_i(waddr_i), .wdata_i(wdata_i),
        .raddr_a_i(raddr_a_i), .rdata_a_o(rdata_a_o),
        .raddr_b_i(raddr_b_i), .rdata_b_o(rdata_b_o),
        .cwp_o(cwp_o), .ovf_o(ovf_o), .unf_o(unf_o)
    );

    // Physical slot of register r in window w, taken from R1, R5 and R6.
    function automatic int ph(input int w, input int r);
        if (r < 8)  return r;
        if (r < 16) return 8 + w * 16 + 8 + (r - 8);
        if (r < 24) return 8 + w * 16 + (r - 16);
        return 8 + ((w + NWIN - 1) % NWIN) * 16 + 8 + (r - 24);
    endfunction

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input int r, input logic [DW-1:0] v);
        we_i = 1'b1; waddr_i = 5'(r); wdata_i = v;
        tick();
        we_i = 1'b0;
    endtask

    task automatic rd(input int ra, input int rb);
        raddr_a_i = 5'(ra); raddr_b_i = 5'(rb);
        #1;
    endtask

    task automatic cmd(input bit s, input bit r);
        save_i = s; restore_i = r;
        tick();
        save_i = 1'b0; restore_i = 1'b0;
    endtask

    task automatic sweep_read(input int w, input string req);
        for (int r = 0; r < 32; r++) begin
            rd(r, 31 - r);
            chk(req, rdata_a_o, (r == 0) ? '0 : model[ph(w, r)]);
            chk(req, rdata_b_o, (31 - r == 0) ? '0 : model[ph(w, 31 - r)]);
        end
    endtask

    initial begin
        for (int i = 0; i < NPHYS; i++) model[i] = '0;
        tick(); tick();
        rst_n = 1'b1;
        tick();

        // R11: reset state
        chk("R11 cwp", 32'(cwp_o), 0);
        chk("R11 ovf", 32'(ovf_o), 0);
        chk("R11 unf", 32'(unf_o), 0);
        sweep_read(0, "R11 regs zero");

        // R2: write to register 0 is discarded, and reads zero even in the write cycle
        we_i = 1'b1; waddr_i = 5'd0; wdata_i = 32'hDEAD_BEEF;
        rd(0, 0);
        chk("R2 same-cycle A", rdata_a_o, '0);
        chk("R2 same-cycle B", rdata_b_o, '0);
        tick(); we_i = 1'b0;
        rd(0, 0);
        chk("R2 after write", rdata_a_o, '0);

        // R5: outs of window 0 appear as ins of window 1
        wr(9, 32'h5555_0009);
        model[ph(0, 9)] = 32'h5555_0009;
        cmd(1'b1, 1'b0);
        chk("R3 cwp after save", 32'(cwp_o), 1);
        rd(25, 9);
        chk("R5 in25 of w1", rdata_a_o, 32'h5555_0009);
        cmd(1'b0, 1'b1);
        chk("R4 cwp after restore", 32'(cwp_o), 0);

        // Sweep: write every register in windows 0..NWIN-2
        for (int w = 0; w < NWIN - 1; w++) begin
            for (int r = 1; r < 32; r++) begin
                logic [DW-1:0] v;
                v = 32'hA000_0000 | (32'(w) << 8) | 32'(r);
                wr(r, v);
                model[ph(w, r)] = v;
            end
            if (w < NWIN - 2) begin
                cmd(1'b1, 1'b0);
                chk("R3 save step", 32'(cwp_o), 32'(w + 1));
                chk("R3 no ovf", 32'(ovf_o), 0);
            end
        end

        // R7: save with 7 windows resident
        cmd(1'b1, 1'b0);
        chk("R7 ovf pulse", 32'(ovf_o), 1);
        chk("R7 cwp held", 32'(cwp_o), NWIN - 2);
        tick();
        chk("R7 ovf one cycle", 32'(ovf_o), 0);

        // R10: simultaneous save and restore
        cmd(1'b1, 1'b1);
        chk("R10 cwp", 32'(cwp_o), NWIN - 2);
        chk("R10 ovf", 32'(ovf_o), 0);
        chk("R10 unf", 32'(unf_o), 0);

        // Read back every window walking down (R1, R5, R6, R4)
        for (int w = NWIN - 2; w >= 0; w--) begin
            sweep_read(w, "R1/R5/R6 readback");
            if (w > 0) begin
                cmd(1'b0, 1'b1);
                chk("R4 restore step", 32'(cwp_o), 32'(w - 1));
                chk("R4 no unf", 32'(unf_o), 0);
            end
        end

        // R6: local written in window 0 is invisible from window 1
        wr(17, 32'h0BAD_0017);
        model[ph(0, 17)] = 32'h0BAD_0017;
        cmd(1'b1, 1'b0);
        rd(17, 1);
        chk("R6 local private", rdata_a_o, model[ph(1, 17)]);
        chk("R1 global shared", rdata_b_o, model[1]);
        cmd(1'b0, 1'b1);

        // R8: restore with one resident window
        cmd(1'b0, 1'b1);
        chk("R8 unf pulse", 32'(unf_o), 1);
        chk("R8 cwp held", 32'(cwp_o), 0);
        tick();
        chk("R8 unf one cycle", 32'(unf_o), 0);

        // R9: same-cycle bypass on both ports
        we_i = 1'b1; waddr_i = 5'd20; wdata_i = 32'h1234_5678;
        rd(20, 20);
        chk("R9 bypass A", rdata_a_o, 32'h1234_5678);
        chk("R9 bypass B", rdata_b_o, 32'h1234_5678);
        rd(20, 21);
        chk("R9 no bypass other", rdata_b_o, model[ph(0, 21)]);
        tick(); we_i = 1'b0;
        rd(20, 0);
        chk("R9 stored", rdata_a_o, 32'h1234_5678);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule